// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the serial front end of a timekeeping chip. An external master reaches the clock, alarm, control, status, trickle-charge and user-RAM registers through it. A strap input picks the wire protocol. In four-wire SPI, data enters on one pin and leaves on another. In three-wire mode the two data pins are joined outside the block into one shared line, and the block asks for that line only while it is returning read data. Every transfer sits inside a high pulse on the chip-enable input. The first byte is an address byte. Data bytes follow, and the register address steps forward after each data byte, so one transfer can carry a single byte or a burst.

The serial pins are resampled by a fast system clock, so no logic is clocked by the serial clock. When chip enable rises, the block records the level of the serial clock as the idle polarity. The control register and the trickle register are held inside the block, because write protection and the charger key must be enforced there. The reserved addresses are answered locally as well. Every other register lives outside the block and is reached through a simple single-cycle register bus.

The controller has five states:
- IDLE waits for chip enable to rise.
- ADDR collects the address byte.
- WDATA collects write bytes.
- RFETCH spends two cycles fetching one read byte.
- RDATA shifts that byte out.

The transitions are:
- IDLE goes to ADDR on a rising chip enable.
- ADDR goes to WDATA when the eighth bit completes a write address, or to RFETCH when it completes a read address.
- RFETCH goes to RDATA after its second cycle.
- RDATA goes back to RFETCH when the eighth bit of a byte is strobed.
- Every state other than IDLE returns to IDLE as soon as chip enable is low.

Top module: `ser_reg_slave`

## Requirements
- R1: A transfer starts when the resampled chip enable rises and ends when it falls. No bus strobe is raised outside a transfer, and sdo_oe is low one cycle after the resampled chip enable goes low.
- R2: The sclk level seen when chip enable rises is the idle level. sdi is sampled on each edge that leaves the idle level, and the sdo bit changes on the edge that returns to it. Both idle-low and idle-high masters work.
- R3: Bits travel MSB first. In the address byte, bit 7 = 1 means write, and bits 6:0 hold the register address, so a register read at address A is written at A+80h.
- R4: After each complete data byte the address steps forward by one. Within 00h–1Fh it wraps from 1Fh to 00h, and within the RAM region 20h–7Fh it wraps from 7Fh to 20h.
- R5: A data byte cut short by a falling chip enable has no effect. Bytes completed earlier in the same burst are kept.
- R6: Control bit 6 is the write-protect bit. While it is 1, no bus write occurs and the trickle register and control bits 2:0 keep their values. The only write that has an effect is one to 8Fh with bit 6 = 0, and that write clears only the protect bit.
- R7: The control register is read at 0Fh and written at 8Fh. It keeps bits 6, 2, 1 and 0, and its other bits read 0.
- R8: Reading addresses 12h–1Fh returns 00h. Writes to 92h–9Fh change nothing and create no bus write.
- R9: The trickle register is read at 11h and written at 91h. trickle_on is 1 only when bits 7:4 hold 1010b and bits 1:0 are not 00b.
- R10: With mode_spi = 0 (three-wire), sdo_oe is high only during the data phase of a read. With mode_spi = 1 it is high for the whole transfer.
- R11: A write to an external address gives a one-cycle bus_we, with bus_addr and bus_wdata valid in that cycle. A read gives a one-cycle bus_re, and bus_rdata is taken in the following cycle with bus_addr unchanged.
- R12: After reset, sdo_oe, bus_we, bus_re and trickle_on are 0, and the control and trickle registers hold 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to resample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_spi | input | 1 | Strap input: 1 selects four-wire SPI, 0 selects three-wire |
| ce | input | 1 | Chip enable, active high, frames a transfer |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in (the shared line in three-wire mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| bus_addr | output | 7 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_we | output | 1 | Register bus write strobe, one cycle |
| bus_re | output | 1 | Register bus read strobe, one cycle |
| bus_rdata | input | 8 | Register bus read data, taken the cycle after bus_re |
| ctrl_reg | output | 8 | Control register contents |
| trickle_reg | output | 8 | Trickle register contents |
| trickle_on | output | 1 | Trickle charger enable |

## Verification
The hardest situation to reach is a protected register file that receives writes which must either be dropped or allowed to clear only the protect bit. Reaching it needs a chain of full serial transfers: one to set the protect bit, several that try to change RAM, the trickle register and the low control bits, and then the single clearing write. A second hard case is a burst cut off in the middle of a byte. The bench completes whole bytes first and then drops chip enable after a few bits, which shows that completed bytes are kept and the partial byte is not. Burst wrap at both region ends is reached by starting reads and writes one or two addresses below the boundary, with both idle clock levels.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RFETCH,
        ST_RDATA
    } srs_state_e;

    // register map boundaries the behaviour depends on
    localparam logic [ADDR_W-1:0] CLK_LO    = 7'h00;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
    localparam logic [ADDR_W-1:0] TRK_ADDR  = 7'h11;
    localparam logic [ADDR_W-1:0] RSV_LO    = 7'h12;
    localparam logic [ADDR_W-1:0] RSV_HI    = 7'h1F;
    localparam logic [ADDR_W-1:0] RAM_LO    = 7'h20;
    localparam logic [ADDR_W-1:0] RAM_HI    = 7'h7F;

    localparam int              WP_BIT    = 6;
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'h47;
    localparam logic [3:0]      TRK_KEY   = 4'hA;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        if (a == RAM_HI)      return RAM_LO;
        else if (a == RSV_HI) return CLK_LO;
        else                  return a + 7'd1;
    endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    if (STAGES < 2) begin : g_single
        logic [W-1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= d_in;
        end
        assign q_out = stage_q;
    end else begin : g_chain
        logic [STAGES-1:0][W-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_in};
        end
        assign q_out = chain_q[STAGES-1];
    end
endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_byte,
    output logic              rd_stb,
    output logic              sdo_bit,
    output logic              rd_phase,
    output logic              xfer_on
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    srs_state_e state, nxt;

    logic              cpol;
    logic              ce_d;
    logic              sclk_d;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-2:0] shin;
    logic [DATA_W-1:0] shout;
    logic [DATA_W-1:0] hold;
    logic              load_pend;
    logic              fetch_ph;
    logic [ADDR_W-1:0] addr_q;

    logic              ce_rise;
    logic              edge_up;
    logic              edge_dn;
    logic              strobe;
    logic              shift;
    logic              byte_done;
    logic [DATA_W-1:0] assembled;

    assign ce_rise   = ce_s & ~ce_d;
    assign edge_up   = sclk_s & ~sclk_d;
    assign edge_dn   = ~sclk_s & sclk_d;
    assign strobe    = (state != ST_IDLE) && (state != ST_RFETCH) && (cpol ? edge_dn : edge_up);
    assign shift     = (state == ST_RDATA) && (cpol ? edge_up : edge_dn);
    assign byte_done = strobe && (bitcnt == LAST_BIT);
    assign assembled = {shin, sdi_s};

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (ce_rise) nxt = ST_ADDR;
            ST_ADDR: begin
                if (!ce_s)          nxt = ST_IDLE;
                else if (byte_done) nxt = shin[DATA_W-2] ? ST_WDATA : ST_RFETCH;
            end
            ST_WDATA:  if (!ce_s) nxt = ST_IDLE;
            ST_RFETCH: begin
                if (!ce_s)          nxt = ST_IDLE;
                else if (fetch_ph)  nxt = ST_RDATA;
            end
            ST_RDATA: begin
                if (!ce_s)          nxt = ST_IDLE;
                else if (byte_done) nxt = ST_RFETCH;
            end
            default:                nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol      <= 1'b0;
            ce_d      <= 1'b0;
            sclk_d    <= 1'b0;
            bitcnt    <= '0;
            shin      <= '0;
            shout     <= '0;
            hold      <= '0;
            load_pend <= 1'b0;
            fetch_ph  <= 1'b0;
            addr_q    <= '0;
        end else begin
            ce_d   <= ce_s;
            sclk_d <= sclk_s;
            if (state == ST_IDLE) begin
                bitcnt    <= '0;
                load_pend <= 1'b0;
                fetch_ph  <= 1'b0;
                shout     <= '0;
                if (ce_rise) cpol <= sclk_s;
            end else begin
                if (strobe) begin
                    bitcnt <= bitcnt + 1'b1;
                    shin   <= assembled[DATA_W-2:0];
                end
                if (byte_done && state == ST_ADDR)
                    addr_q <= assembled[ADDR_W-1:0];
                if (byte_done && (state == ST_WDATA || state == ST_RDATA))
                    addr_q <= next_addr(addr_q);
                if (state == ST_RFETCH) begin
                    fetch_ph <= ~fetch_ph;
                    if (fetch_ph) begin
                        hold      <= rd_byte;
                        load_pend <= 1'b1;
                    end
                end
                if (shift) begin
                    if (load_pend) begin
                        shout     <= hold;
                        load_pend <= 1'b0;
                    end else begin
                        shout     <= {shout[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        acc_addr = addr_q;
        wr_byte  = assembled;
        wr_stb   = (state == ST_WDATA) && byte_done;
        rd_stb   = (state == ST_RFETCH) && !fetch_ph;
        rd_phase = (state == ST_RFETCH) || (state == ST_RDATA);
        xfer_on  = (state != ST_IDLE);
        sdo_bit  = rd_phase ? shout[DATA_W-1] : 1'b0;
    end
endmodule

// File: rtl/srs_regs.sv
module srs_regs
    import srs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] trk_q,
    output logic              trk_on
);
    logic is_ctrl;
    logic is_trk;
    logic is_rsv;
    logic is_ext;
    logic wp;

    assign is_ctrl = (acc_addr == CTRL_ADDR);
    assign is_trk  = (acc_addr == TRK_ADDR);
    assign is_rsv  = (acc_addr >= RSV_LO) && (acc_addr <= RSV_HI);
    assign is_ext  = !(is_ctrl || is_trk || is_rsv);
    assign wp      = ctrl_q[WP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            trk_q  <= '0;
        end else if (wr_stb) begin
            if (wp) begin
                if (is_ctrl && !wr_byte[WP_BIT]) ctrl_q[WP_BIT] <= 1'b0;
            end else begin
                if (is_ctrl) ctrl_q <= wr_byte & CTRL_MASK;
                if (is_trk)  trk_q  <= wr_byte;
            end
        end
    end

    always_comb begin
        bus_addr  = acc_addr;
        bus_wdata = wr_byte;
        bus_we    = wr_stb && !wp && is_ext;
        bus_re    = rd_stb && is_ext;
        if (is_ctrl)     rd_byte = ctrl_q;
        else if (is_trk) rd_byte = trk_q;
        else if (is_rsv) rd_byte = '0;
        else             rd_byte = bus_rdata;
        trk_on = (trk_q[DATA_W-1:DATA_W-4] == TRK_KEY) && (trk_q[1:0] != 2'b00);
    end
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
    import srs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_spi,
    input  logic              ce,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_reg,
    output logic [DATA_W-1:0] trickle_reg,
    output logic              trickle_on
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_stb;
    logic [DATA_W-1:0] wr_byte;
    logic              rd_stb;
    logic [DATA_W-1:0] rd_byte;
    logic              sdo_bit;
    logic              rd_phase;
    logic              xfer_on;

    srs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ce, sclk, sdi}),
        .q_out (pins_s)
    );

    srs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .rd_byte  (rd_byte),
        .acc_addr (acc_addr),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .rd_stb   (rd_stb),
        .sdo_bit  (sdo_bit),
        .rd_phase (rd_phase),
        .xfer_on  (xfer_on)
    );

    srs_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte),
        .rd_stb    (rd_stb),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .rd_byte   (rd_byte),
        .ctrl_q    (ctrl_reg),
        .trk_q     (trickle_reg),
        .trk_on    (trickle_on)
    );

    assign sdo    = sdo_bit;
    assign sdo_oe = mode_spi ? xfer_on : rd_phase;
endmodule

// File: rtl/ser_reg_slave_chk.sv
module ser_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_spi,
    input logic       bus_we,
    input logic       bus_re,
    input logic       sdo_oe,
    input logic       xfer_on,
    input logic [7:0] ctrl_reg,
    input logic [7:0] trickle_reg
);
    // R11: strobes never overlap and last one cycle
    a_r11_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
    a_r11_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);
    a_r11_re_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re);
    // R1: bus traffic only inside a transfer
    a_r1_bus_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |-> xfer_on);
    // R6: protection freezes the trickle register and the low control bits
    a_r6_wp_freezes_trickle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg[6] |=> $stable(trickle_reg));
    a_r6_wp_freezes_enables: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reg[6] |=> $stable(ctrl_reg[2:0]));
    // R10: in three-wire mode the line is never driven while a write lands
    a_r10_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_spi && sdo_oe) |-> !bus_we);
endmodule

bind ser_reg_slave ser_reg_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_spi    (mode_spi),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .sdo_oe      (sdo_oe),
    .xfer_on     (xfer_on),
    .ctrl_reg    (ctrl_reg),
    .trickle_reg (trickle_reg)
);

// File: tb/sim_ser_reg_slave.sv
module sim_ser_reg_slave;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_spi = 1'b1;
    logic       ce = 1'b0;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [6:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_we;
    logic       bus_re;
    logic [7:0] bus_rdata;
    logic [7:0] ctrl_reg;
    logic [7:0] trickle_reg;
    logic       trickle_on;

    always #10 clk = ~clk;

    ser_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_spi(mode_spi), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .ctrl_reg(ctrl_reg),
        .trickle_reg(trickle_reg), .trickle_on(trickle_on)
    );

    // external register file seen on the bus
    logic [7:0] slave_mem [128];
    assign bus_rdata = slave_mem[bus_addr];
    always @(posedge clk) if (bus_we) slave_mem[bus_addr] <= bus_wdata;

    // reference model
    logic [7:0]  ref_mem [128];
    logic [7:0]  ref_ctrl = 8'h00;
    logic [7:0]  ref_trk  = 8'h00;
    logic [14:0] exp_q [$];
    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] m_next(input logic [6:0] a);
        if (a == 7'h7F) return 7'h20;
        if (a == 7'h1F) return 7'h00;
        return a + 7'd1;
    endfunction

    function automatic bit m_ext(input logic [6:0] a);
        return !(a == 7'h0F || a == 7'h11 || (a >= 7'h12 && a <= 7'h1F));
    endfunction

    function automatic void m_write(input logic [6:0] a, input logic [7:0] d);
        if (ref_ctrl[6]) begin
            if (a == 7'h0F && !d[6]) ref_ctrl[6] = 1'b0;
        end else if (a == 7'h0F) ref_ctrl = d & 8'h47;
        else if (a == 7'h11)     ref_trk = d;
        else if (m_ext(a)) begin
            ref_mem[a] = d;
            exp_q.push_back({a, d});
        end
    endfunction

    function automatic logic [7:0] m_read(input logic [6:0] a);
        if (a == 7'h0F) return ref_ctrl;
        if (a == 7'h11) return ref_trk;
        if (a >= 7'h12 && a <= 7'h1F) return 8'h00;
        return ref_mem[a];
    endfunction

    // per-clock comparison of bus writes against the model (R11)
    always @(negedge clk) begin
        if (rst_n && bus_we) begin
            if (exp_q.size() == 0) chk("R11", "unexpected bus write addr", int'(bus_addr), 255);
            else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk("R11", "bus write addr", int'(bus_addr), int'(e[14:8]));
                chk("R11", "bus write data", int'(bus_wdata), int'(e[7:0]));
            end
        end
    end

    task automatic wait_hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic tx_begin(input logic pol);
        sclk = pol;
        wait_hp();
        ce = 1'b1;
        wait_hp();
    endtask

    task automatic tx_end();
        wait_hp();
        ce = 1'b0;
        sdi = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "sdo_oe after end", int'(sdo_oe), 0);
        repeat (2 * HP) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input logic pol,
                             input bit oe_chk, input logic oe_exp);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            wait_hp();
            if (oe_chk) chk("R10", "sdo_oe while master drives", int'(sdo_oe), int'(oe_exp));
            sclk = ~pol;
            wait_hp();
            sclk = pol;
        end
    endtask

    task automatic recv_byte(input logic pol, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_hp();
            b[i] = sdo;
            chk("R10", "sdo_oe during read data", int'(sdo_oe), 1);
            sclk = ~pol;
            wait_hp();
            sclk = pol;
        end
    endtask

    task automatic do_write(input logic spi, input logic pol, input logic [6:0] a,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input int n, input string req);
        logic [6:0] cur;
        logic [7:0] dv;
        mode_spi = spi;
        cur = a;
        tx_begin(pol);
        send_bits({1'b1, a}, 8, pol, 1'b1, spi);
        for (int k = 0; k < n; k++) begin
            dv = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            m_write(cur, dv);
            send_bits(dv, 8, pol, 1'b1, spi);
            cur = m_next(cur);
        end
        tx_end();
        chk(req, "pending expected writes", exp_q.size(), 0);
    endtask

    task automatic do_read(input logic spi, input logic pol, input logic [6:0] a,
                           input int n, input string req);
        logic [6:0] cur;
        logic [7:0] got;
        mode_spi = spi;
        cur = a;
        tx_begin(pol);
        send_bits({1'b0, a}, 8, pol, 1'b1, spi);
        for (int k = 0; k < n; k++) begin
            recv_byte(pol, got);
            chk(req, $sformatf("read data at %0h", cur), int'(got), int'(m_read(cur)));
            cur = m_next(cur);
        end
        tx_end();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            slave_mem[i] = 8'((i * 37 + 5) & 255);
            ref_mem[i]   = 8'((i * 37 + 5) & 255);
        end
        repeat (5) @(negedge clk);
        // R12: reset state
        chk("R12", "sdo_oe in reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12", "sdo_oe", int'(sdo_oe), 0);
        chk("R12", "bus_we", int'(bus_we), 0);
        chk("R12", "bus_re", int'(bus_re), 0);
        chk("R12", "trickle_on", int'(trickle_on), 0);
        chk("R12", "ctrl_reg", int'(ctrl_reg), 0);
        chk("R12", "trickle_reg", int'(trickle_reg), 0);

        // R3: single byte write and read, idle-low clock, SPI
        do_write(1'b1, 1'b0, 7'h25, 8'hA5, 8'h00, 8'h00, 1, "R3");
        do_read (1'b1, 1'b0, 7'h25, 1, "R3");

        // R2/R4: idle-high clock, bursts across the RAM wrap
        do_write(1'b1, 1'b1, 7'h7E, 8'h11, 8'h22, 8'h33, 3, "R4");
        do_read (1'b1, 1'b1, 7'h7E, 3, "R2");

        // R4/R8: burst read across reserved area and clock-region wrap
        do_read (1'b1, 1'b0, 7'h1D, 4, "R4");

        // R10: three-wire mode, write and read
        do_write(1'b0, 1'b0, 7'h26, 8'h5A, 8'h00, 8'h00, 1, "R10");
        do_read (1'b0, 1'b0, 7'h26, 2, "R10");
        do_read (1'b0, 1'b1, 7'h7F, 2, "R2");

        // R5: truncated single byte and truncated burst tail
        mode_spi = 1'b1;
        tx_begin(1'b0);
        send_bits(8'hB0, 8, 1'b0, 1'b0, 1'b1);
        send_bits(8'hC3, 5, 1'b0, 1'b0, 1'b1);
        tx_end();
        chk("R5", "pending expected writes", exp_q.size(), 0);
        do_read(1'b1, 1'b0, 7'h30, 1, "R5");
        tx_begin(1'b1);
        send_bits(8'hB1, 8, 1'b1, 1'b0, 1'b1);
        m_write(7'h31, 8'h77);
        send_bits(8'h77, 8, 1'b1, 1'b0, 1'b1);
        send_bits(8'h0F, 3, 1'b1, 1'b0, 1'b1);
        tx_end();
        chk("R5", "pending expected writes", exp_q.size(), 0);
        do_read(1'b1, 1'b0, 7'h31, 2, "R5");

        // R9: trickle key
        do_write(1'b1, 1'b0, 7'h11, 8'hA1, 8'h00, 8'h00, 1, "R9");
        chk("R9", "trickle_on key+res", int'(trickle_on), 1);
        do_read(1'b1, 1'b0, 7'h11, 1, "R9");
        do_write(1'b1, 1'b0, 7'h11, 8'hA0, 8'h00, 8'h00, 1, "R9");
        chk("R9", "trickle_on res=00", int'(trickle_on), 0);
        do_write(1'b1, 1'b0, 7'h11, 8'hB1, 8'h00, 8'h00, 1, "R9");
        chk("R9", "trickle_on bad key", int'(trickle_on), 0);
        do_write(1'b1, 1'b0, 7'h11, 8'hA2, 8'h00, 8'h00, 1, "R9");
        chk("R9", "trickle_on key+res2", int'(trickle_on), 1);

        // R8: reserved write has no effect, reserved read is zero
        do_write(1'b1, 1'b0, 7'h15, 8'hFF, 8'h00, 8'h00, 1, "R8");
        do_read (1'b1, 1'b1, 7'h15, 1, "R8");

        // R7: control register keeps bits 6,2,1,0
        do_write(1'b1, 1'b0, 7'h0F, 8'hFF, 8'h00, 8'h00, 1, "R7");
        chk("R7", "ctrl_reg", int'(ctrl_reg), int'(ref_ctrl));
        chk("R7", "ctrl_reg value", int'(ctrl_reg), 8'h47);
        do_read(1'b1, 1'b0, 7'h0F, 1, "R7");

        // R6: protection
        do_write(1'b1, 1'b0, 7'h25, 8'h00, 8'h00, 8'h00, 1, "R6");
        do_read (1'b1, 1'b0, 7'h25, 1, "R6");
        do_write(1'b1, 1'b0, 7'h11, 8'h00, 8'h00, 8'h00, 1, "R6");
        chk("R6", "trickle_on under protect", int'(trickle_on), 1);
        chk("R6", "trickle_reg under protect", int'(trickle_reg), 8'hA2);
        do_write(1'b1, 1'b0, 7'h0F, 8'h40, 8'h00, 8'h00, 1, "R6");
        chk("R6", "ctrl kept under protect", int'(ctrl_reg), 8'h47);
        do_write(1'b1, 1'b1, 7'h0F, 8'h00, 8'h00, 8'h00, 1, "R6");
        chk("R6", "ctrl after clearing write", int'(ctrl_reg), 8'h07);
        do_write(1'b1, 1'b0, 7'h0F, 8'h00, 8'h00, 8'h00, 1, "R6");
        chk("R6", "ctrl after unprotected write", int'(ctrl_reg), 8'h00);
        do_write(1'b1, 1'b0, 7'h25, 8'h3C, 8'h00, 8'h00, 1, "R6");
        do_read (1'b1, 1'b0, 7'h25, 1, "R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule